// File: doc/BRIEF.md
# RTC Time-Base Divider and Update Timer

This block turns a 32.768 kHz time-base enable into the timing signals a real-time clock needs. A 15-bit binary countdown chain advances by one on every enabled time-base tick. A 4-bit rate code picks one of thirteen chain bits. That one selection feeds both a square-wave pin and a periodic-event pulse, so the two always run at the same rate.

The most significant stage of the chain produces a once-per-second update strobe for the calendar logic that sits outside this block. A busy flag warns software eight ticks (about 244 µs) before each strobe. A done pulse follows one tick after each strobe. A 3-bit control field sets the chain state: it can run, it can be held cleared with the oscillator still running, or it can stop. A freeze input suppresses update strobes while software rewrites the time registers.

Top module: `rtc_timebase`

## Requirements
- R1: While the control field is 3'b010, the chain advances by one on each clock cycle where `tb_tick` is high. It does not change on cycles where `tb_tick` is low.
- R2: Rate codes select chain bit k, whose square wave has a period of 2^(k+1) ticks. The mapping is: code 1 selects bit 6 (256 Hz), code 2 selects bit 7 (128 Hz), code 3 selects bit 1 (8192 Hz), and codes 4 to 15 select bits 2 to 13 (4096 Hz down to 2 Hz).
- R3: Rate code 0 selects no bit. `sqw_out` stays low and no periodic events are produced.
- R4: When `sqw_enable` is 0, `sqw_out` is held low and periodic events keep firing. When it is 1, `sqw_out` equals the selected chain bit.
- R5: `periodic_evt` is a one-cycle pulse in the cycle after the selected chain bit goes from 0 to 1.
- R6: Control values 3'b110 and 3'b111 clear the whole chain and keep it cleared. During that time there are no periodic events, no update strobes and no busy flag. After the field changes to 3'b010, the first update strobe comes 16384 ticks later.
- R7: All other control values freeze the chain at its current count. The chain produces no events while frozen and resumes from that count when 3'b010 returns.
- R8: `update_strobe` pulses for one cycle each time the chain count moves from 16383 to 16384, which is once every 32768 ticks.
- R9: `update_busy` is high for the 8 ticks just before each update strobe, while the count is 16376 to 16383, and is low at every other time.
- R10: While `set_freeze` is 1, `update_busy` is low, no update strobe occurs and no done pulse follows.
- R11: `update_done` pulses for one cycle on the first tick after an update strobe.
- R12: A synchronous reset clears the chain and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | One-cycle enable at 32.768 kHz |
| div_ctrl | input | 3 | Chain control: 010 run, 11x hold cleared, other values stop |
| rate_code | input | 4 | Tap selection shared by the square wave and periodic event |
| sqw_enable | input | 1 | Lets the selected tap reach `sqw_out` |
| set_freeze | input | 1 | Suppresses update transfers and the busy flag |
| sqw_out | output | 1 | Square-wave output |
| periodic_evt | output | 1 | One-cycle pulse on each rising edge of the selected tap |
| update_strobe | output | 1 | One-cycle once-per-second update pulse |
| update_busy | output | 1 | High during the 8 ticks before an update |
| update_done | output | 1 | One-cycle pulse one tick after an update |

## Verification
The assertions check the invariants that hold on every cycle: the gated square wave stays low, a hold or stop produces no events, a strobe is always preceded by a busy cycle, freeze keeps busy low and blocks strobes, and events only follow a tick. Only the bench scenarios can show the exact tap each rate code picks and the phase of each periodic pulse. The same is true of the 16384-tick delay to the first update after a hold and the 32768-tick spacing after it. They also show that a stopped chain resumes its count while a held chain restarts from zero.

// File: rtl/rtc_timebase_pkg.sv
`timescale 1ns/1ps
package rtc_timebase_pkg;

    localparam int CHAIN_STAGES = 15;
    localparam int BUSY_TICKS   = 8;

    typedef enum logic [1:0] {
        CHAIN_STOP = 2'd0,
        CHAIN_RUN  = 2'd1,
        CHAIN_HOLD = 2'd2
    } chain_mode_e;

    typedef struct packed {
        logic       valid;
        logic [3:0] bit_idx;
    } tap_sel_t;

    // 11x holds the chain cleared, 010 runs it, anything else stops it
    function automatic chain_mode_e decode_ctrl(input logic [2:0] ctrl);
        chain_mode_e m;
        if (ctrl[2:1] == 2'b11)
            m = CHAIN_HOLD;
        else if (ctrl == 3'b010)
            m = CHAIN_RUN;
        else
            m = CHAIN_STOP;
        return m;
    endfunction

    // rate code to chain bit; the three low codes are irregular
    function automatic tap_sel_t rate_to_tap(input logic [3:0] code);
        tap_sel_t t;
        t.valid = 1'b1;
        case (code)
            4'd0:    begin t.valid = 1'b0; t.bit_idx = 4'd0; end
            4'd1:    t.bit_idx = 4'd6;
            4'd2:    t.bit_idx = 4'd7;
            4'd3:    t.bit_idx = 4'd1;
            default: t.bit_idx = code - 4'd2;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rtc_div_chain.sv
`timescale 1ns/1ps
module rtc_div_chain
    import rtc_timebase_pkg::*;
#(
    parameter int STAGES = CHAIN_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  chain_mode_e       mode,
    output logic [STAGES-1:0] count,
    output logic              advance
);

    assign advance = tick && (mode == CHAIN_RUN);

    always_ff @(posedge clk) begin
        if (rst || mode == CHAIN_HOLD)
            count <= '0;
        else if (advance)
            count <= count + STAGES'(1);
    end

endmodule

// File: rtl/rtc_tap_select.sv
`timescale 1ns/1ps
module rtc_tap_select
    import rtc_timebase_pkg::*;
#(
    parameter int STAGES = CHAIN_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] count,
    input  logic              advance,
    input  logic [3:0]        rate_code,
    input  logic              sqw_enable,
    output logic              sqw_out,
    output logic              periodic_evt
);

    tap_sel_t          sel;
    logic [STAGES-1:0] count_next;
    logic              tap_now;
    logic              tap_next;

    assign sel        = rate_to_tap(rate_code);
    assign count_next = count + STAGES'(1);
    assign tap_now    = sel.valid && count[sel.bit_idx];
    assign tap_next   = sel.valid && count_next[sel.bit_idx];
    assign sqw_out    = sqw_enable && tap_now;

    always_ff @(posedge clk) begin
        if (rst)
            periodic_evt <= 1'b0;
        else
            periodic_evt <= advance && !tap_now && tap_next;
    end

endmodule

// File: rtl/rtc_update_timer.sv
`timescale 1ns/1ps
module rtc_update_timer
    import rtc_timebase_pkg::*;
#(
    parameter int STAGES = CHAIN_STAGES,
    parameter int WINDOW = BUSY_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              advance,
    input  chain_mode_e       mode,
    input  logic              set_freeze,
    input  logic [STAGES-1:0] count,
    output logic              update_strobe,
    output logic              update_busy,
    output logic              update_done
);

    localparam int                UPD_POINT = 1 << (STAGES - 1);
    localparam logic [STAGES-1:0] LAST_CNT  = STAGES'(UPD_POINT - 1);
    localparam logic [STAGES-1:0] WIN_LO    = STAGES'(UPD_POINT - WINDOW);

    logic hit;
    logic done_pend;

    assign update_busy = (mode == CHAIN_RUN) && !set_freeze
                         && (count >= WIN_LO) && (count <= LAST_CNT);
    assign hit         = advance && !set_freeze && (count == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst || mode == CHAIN_HOLD) begin
            update_strobe <= 1'b0;
            update_done   <= 1'b0;
            done_pend     <= 1'b0;
        end else begin
            update_strobe <= hit;
            update_done   <= tick && done_pend;
            if (hit)
                done_pend <= 1'b1;
            else if (tick)
                done_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase
    import rtc_timebase_pkg::*;
#(
    parameter int STAGES = CHAIN_STAGES,
    parameter int WINDOW = BUSY_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tb_tick,
    input  logic [2:0] div_ctrl,
    input  logic [3:0] rate_code,
    input  logic       sqw_enable,
    input  logic       set_freeze,
    output logic       sqw_out,
    output logic       periodic_evt,
    output logic       update_strobe,
    output logic       update_busy,
    output logic       update_done
);

    chain_mode_e       mode;
    logic [STAGES-1:0] count;
    logic              advance;

    assign mode = decode_ctrl(div_ctrl);

    rtc_div_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .tick    (tb_tick),
        .mode    (mode),
        .count   (count),
        .advance (advance)
    );

    rtc_tap_select #(.STAGES(STAGES)) u_tap (
        .clk          (clk),
        .rst          (rst),
        .count        (count),
        .advance      (advance),
        .rate_code    (rate_code),
        .sqw_enable   (sqw_enable),
        .sqw_out      (sqw_out),
        .periodic_evt (periodic_evt)
    );

    rtc_update_timer #(.STAGES(STAGES), .WINDOW(WINDOW)) u_upd (
        .clk           (clk),
        .rst           (rst),
        .tick          (tb_tick),
        .advance       (advance),
        .mode          (mode),
        .set_freeze    (set_freeze),
        .count         (count),
        .update_strobe (update_strobe),
        .update_busy   (update_busy),
        .update_done   (update_done)
    );

endmodule

// File: rtl/rtc_timebase_chk.sv
`timescale 1ns/1ps
module rtc_timebase_chk (
    input logic       clk,
    input logic       rst,
    input logic       tb_tick,
    input logic [2:0] div_ctrl,
    input logic [3:0] rate_code,
    input logic       sqw_enable,
    input logic       set_freeze,
    input logic       sqw_out,
    input logic       periodic_evt,
    input logic       update_strobe,
    input logic       update_busy,
    input logic       update_done
);

    assert_events_need_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (periodic_evt || update_strobe) |-> $past(tb_tick));

    assert_no_rate_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (rate_code == 4'd0) |=> !periodic_evt);

    assert_gate_low_R4: assert property (@(posedge clk) disable iff (rst)
        !sqw_enable |-> !sqw_out);

    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (div_ctrl[2:1] == 2'b11) |=> (!periodic_evt && !update_strobe));

    assert_hold_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (div_ctrl[2:1] == 2'b11) |-> !update_busy);

    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (div_ctrl != 3'b010) |=> (!periodic_evt && !update_strobe));

    assert_busy_before_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        update_strobe |-> $past(update_busy));

    assert_freeze_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        set_freeze |-> !update_busy);

    assert_freeze_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        set_freeze |=> !update_strobe);

    assert_done_apart_R11: assert property (@(posedge clk) disable iff (rst)
        update_done |-> !update_strobe);

endmodule

bind rtc_timebase rtc_timebase_chk u_chk (.*);

// File: tb/rtc_timebase_test.sv
`timescale 1ns/1ps
module rtc_timebase_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       tb_tick;
    logic [2:0] div_ctrl;
    logic [3:0] rate_code;
    logic       sqw_enable;
    logic       set_freeze;
    logic       sqw_out;
    logic       periodic_evt;
    logic       update_strobe;
    logic       update_busy;
    logic       update_done;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    rtc_timebase uut (
        .clk           (clk),
        .rst           (rst),
        .tb_tick       (tb_tick),
        .div_ctrl      (div_ctrl),
        .rate_code     (rate_code),
        .sqw_enable    (sqw_enable),
        .set_freeze    (set_freeze),
        .sqw_out       (sqw_out),
        .periodic_evt  (periodic_evt),
        .update_strobe (update_strobe),
        .update_busy   (update_busy),
        .update_done   (update_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // chain bit for a rate code, derived from the output frequency
    function automatic int expected_bit(input int code);
        int f;
        case (code)
            0:       return -1;
            1:       f = 256;
            2:       f = 128;
            3:       f = 8192;
            default: f = 4096 >> (code - 4);
        endcase
        for (int k = 0; k < 15; k++)
            if ((32768 >> (k + 1)) == f) return k;
        return -1;
    endfunction

    // hold the chain cleared, then release it to run; returns with count 0
    task automatic restart(input logic [3:0] rate, input logic en, input logic frz);
        @(negedge clk);
        div_ctrl = 3'b110; rate_code = rate; sqw_enable = en;
        set_freeze = frz; tb_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        div_ctrl = 3'b010;
    endtask

    task automatic test_reset();
        rst = 1'b1; tb_tick = 1'b1; div_ctrl = 3'b010; rate_code = 4'd3;
        sqw_enable = 1'b1; set_freeze = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "sqw_out in reset", int'(sqw_out), 0);
        check("R12", "periodic_evt in reset", int'(periodic_evt), 0);
        check("R12", "update_strobe in reset", int'(update_strobe), 0);
        check("R12", "update_done in reset", int'(update_done), 0);
        check("R12", "update_busy in reset", int'(update_busy), 0);
        rst = 1'b0;
    endtask

    task automatic test_taps(input int code, input logic en, input int nmax);
        int b = expected_bit(code);
        int es, ep;
        restart(4'(code), en, 1'b0);
        for (int n = 1; n <= nmax; n++) begin
            @(negedge clk);
            es = (b >= 0 && en) ? ((n >> b) & 1) : 0;
            ep = (b >= 0 && (n % (1 << (b + 1))) == (1 << b)) ? 1 : 0;
            // R2 R3 R4: square wave; R5: edge pulse phase
            check(en ? "R2" : "R4", $sformatf("sqw code %0d n %0d", code, n), int'(sqw_out), es);
            check(b < 0 ? "R3" : "R5", $sformatf("pulse code %0d n %0d", code, n), int'(periodic_evt), ep);
        end
    endtask

    task automatic test_tick_gate();
        restart(4'd3, 1'b1, 1'b0);
        tb_tick = 1'b0;
        repeat (10) @(negedge clk);
        check("R1", "no advance without tick", int'(sqw_out), 0);
        tb_tick = 1'b1;
        @(negedge clk);
        check("R1", "count 1 bit1", int'(sqw_out), 0);
        @(negedge clk);
        check("R1", "count 2 bit1", int'(sqw_out), 1);
    endtask

    task automatic test_hold();
        restart(4'd3, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        check("R6", "count 6 bit1 before hold", int'(sqw_out), 1);
        div_ctrl = 3'b111;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            check("R6", "hold sqw", int'(sqw_out), 0);
            check("R6", "hold pulse", int'(periodic_evt), 0);
            check("R6", "hold busy", int'(update_busy), 0);
        end
        div_ctrl = 3'b010;
        @(negedge clk);
        @(negedge clk);
        check("R6", "restart from zero, count 2", int'(sqw_out), 1);
        @(negedge clk);
        @(negedge clk);
        check("R6", "restart from zero, count 4", int'(sqw_out), 0);
    endtask

    task automatic test_stop();
        restart(4'd3, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R7", "count 2 before stop", int'(sqw_out), 1);
        div_ctrl = 3'b001;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            check("R7", "stop sqw frozen", int'(sqw_out), 1);
            check("R7", "stop pulse", int'(periodic_evt), 0);
        end
        div_ctrl = 3'b010;
        @(negedge clk);
        check("R7", "resume count 3", int'(sqw_out), 1);
        @(negedge clk);
        check("R7", "resume count 4", int'(sqw_out), 0);
        check("R7", "resume edge pulse absent", int'(periodic_evt), 0);
    endtask

    task automatic test_update();
        int m;
        restart(4'd0, 1'b0, 1'b0);
        for (int n = 1; n <= 49154; n++) begin
            @(negedge clk);
            m = n % 32768;
            // R6 first strobe at 16384, R8 every 32768 after
            check((n < 20000) ? "R6" : "R8", $sformatf("strobe n %0d", n),
                  int'(update_strobe), (m == 16384) ? 1 : 0);
            check("R9", $sformatf("busy n %0d", n), int'(update_busy),
                  (m >= 16376 && m <= 16383) ? 1 : 0);
            check("R11", $sformatf("done n %0d", n), int'(update_done),
                  (m == 16385) ? 1 : 0);
        end
    endtask

    task automatic test_freeze();
        restart(4'd0, 1'b0, 1'b1);
        for (int n = 1; n <= 16400; n++) begin
            @(negedge clk);
            check("R10", $sformatf("frozen strobe n %0d", n), int'(update_strobe), 0);
            check("R10", $sformatf("frozen busy n %0d", n), int'(update_busy), 0);
            check("R10", $sformatf("frozen done n %0d", n), int'(update_done), 0);
        end
        set_freeze = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_tick_gate();
        test_taps(3, 1'b1, 16);
        test_taps(4, 1'b1, 32);
        test_taps(1, 1'b1, 256);
        test_taps(2, 1'b1, 512);
        test_taps(6, 1'b1, 64);
        test_taps(13, 1'b1, 8192);
        test_taps(0, 1'b1, 64);
        test_taps(5, 1'b0, 64);
        test_hold();
        test_stop();
        test_update();
        test_freeze();
        finish_run();
    end

endmodule